// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block holds a small, fully associative set of segment descriptors and uses them to turn a 64-bit effective address into a virtual segment identifier. Software loads one entry at a time from a pair of 64-bit words. One word carries the segment identifier and the flags. The other carries the effective segment number, the valid bit and the slot index. Each entry picks its own segment size, either 256 MB or 1 TB. That choice sets how many address bits take part in the compare, and how the virtual page number is put together.

A lookup presents an effective address. One cycle later the block answers with a strobe, a hit flag, the segment identifier, the entry's flags and the virtual page number. The block can also do three other things. It can return the words stored in any slot. It can drop the single entry that matches an effective address. It can drop every entry except slot 0, so that a boot-time mapping held in slot 0 survives a bulk flush.

Top module: `slb_array`

## Requirements
- R1: A write (`wr_en`) takes the slot index from ESID word bits 11:0, the valid bit from ESID word bit 27 and the segment identifier from VSID word bits 63:12. The flags come from the VSID word: 1 TB segment bit 62, large page bit 8, supervisor key bit 11, problem key bit 10, no-execute bit 9, class bit 7.
- R2: A write whose index is 64 or more is ignored. No slot changes and no slot aliases to the index modulo 64.
- R3: A lookup matches a valid entry when EA bits 63:28 equal ESID word bits 63:28 for a 256 MB entry, or when EA bits 63:40 equal ESID word bits 63:40 for a 1 TB entry. Invalid entries never match, and for a 1 TB entry the ESID bits 39:28 are ignored.
- R4: When several entries match, the lowest-index entry is returned.
- R5: `lk_valid` is high for exactly the cycle after `lk_req`. In that cycle `lk_hit` gives the result, `lk_vsid` gives the segment identifier and `lk_flags` = {1T, L, Ks, Kp, N, C} of the chosen entry. On a miss, `lk_vsid`, `lk_flags` and `lk_vpn` are zero.
- R6: `lk_vpn` is (VSID<<28) | EA[39:12] for a 1 TB entry and (VSID<<16) | EA[27:12] for a 256 MB entry.
- R7: `inv_en` clears the valid bit of the entry that a lookup of `inv_ea` would select. On a miss it changes nothing.
- R8: `inv_all` clears the valid bit of every entry except slot 0.
- R9: The read-back outputs give the stored ESID word with bits 26:0 zeroed, and the full stored VSID word, for slot `rd_idx`. An index of 64 or more reads as 0.
- R10: When a write and a lookup fall in the same cycle, the lookup sees the contents from before the write.
- R11: After reset every entry is invalid, every slot reads back as 0 and `lk_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load one entry |
| wr_vsid_word | input | 64 | Segment identifier and flags word |
| wr_esid_word | input | 64 | Segment number, valid and index word |
| rd_idx | input | 12 | Read-back slot index |
| rd_esid_word | output | 64 | Stored ESID word, masked |
| rd_vsid_word | output | 64 | Stored VSID word |
| lk_req | input | 1 | Start a lookup |
| lk_ea | input | 64 | Lookup effective address |
| lk_valid | output | 1 | Lookup result strobe |
| lk_hit | output | 1 | Lookup found an entry |
| lk_vsid | output | 52 | Segment identifier of the hit |
| lk_flags | output | 6 | {1T, L, Ks, Kp, N, C} of the hit |
| lk_vpn | output | 80 | Virtual page number |
| inv_en | input | 1 | Invalidate the entry matching inv_ea |
| inv_ea | input | 64 | Effective address to invalidate |
| inv_all | input | 1 | Invalidate all entries but slot 0 |

## Verification
Lookups are run against a 256 MB entry and a 1 TB entry. The 1 TB probe differs from the stored word only in bits 39:28, so it shows that the compare width follows each entry's own size flag, and both page number layouts are checked. A second pattern places two entries with the same segment number at slots 9 and 2. Removing them one by one with single invalidates shows the lowest-index rule and how a hit moves to the next match. Other patterns probe a slot written with its valid bit clear, an out-of-range index whose low six bits name slot 36, a write and a lookup in the same cycle, and a bulk flush that must leave slot 0 reachable and the other slots unreachable.

// File: rtl/slb_array.sv
module slb_array #(
  parameter int NENT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [63:0] wr_vsid_word,
  input  logic [63:0] wr_esid_word,
  input  logic [11:0] rd_idx,
  output logic [63:0] rd_esid_word,
  output logic [63:0] rd_vsid_word,
  input  logic        lk_req,
  input  logic [63:0] lk_ea,
  output logic        lk_valid,
  output logic        lk_hit,
  output logic [51:0] lk_vsid,
  output logic [5:0]  lk_flags,
  output logic [79:0] lk_vpn,
  input  logic        inv_en,
  input  logic [63:0] inv_ea,
  input  logic        inv_all
);
  localparam int NW = $clog2(NENT);
  localparam logic [11:0] NENT12 = 12'(NENT);

  logic [63:27] esid_q [NENT];
  logic [63:0]  vsid_q [NENT];
  logic [NENT-1:0] ent_valid;

  logic [NENT-1:0] lk_match, inv_match;
  logic lk_any, inv_any;
  logic [NW-1:0] lk_sel, inv_sel;
  logic [63:0] lk_w;
  logic [11:0] wr_idx;
  logic wr_ok, rd_ok;
  logic unused_bits;

  function automatic logic seg_match(logic [63:27] e, logic tb, logic [63:0] ea);
    return tb ? (e[63:40] == ea[63:40]) : (e[63:28] == ea[63:28]);
  endfunction

  for (genvar i = 0; i < NENT; i++) begin : g_cmp
    assign lk_match[i]  = ent_valid[i] && seg_match(esid_q[i], vsid_q[i][62], lk_ea);
    assign inv_match[i] = ent_valid[i] && seg_match(esid_q[i], vsid_q[i][62], inv_ea);
  end

  always_comb begin
    lk_any = 1'b0;
    lk_sel = '0;
    inv_any = 1'b0;
    inv_sel = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (lk_match[i]) begin
        lk_any = 1'b1;
        lk_sel = NW'(i);
      end
      if (inv_match[i]) begin
        inv_any = 1'b1;
        inv_sel = NW'(i);
      end
    end
  end

  assign lk_w   = vsid_q[lk_sel];
  assign wr_idx = wr_esid_word[11:0];
  assign wr_ok  = wr_idx < NENT12;
  assign rd_ok  = rd_idx < NENT12;

  assign rd_esid_word = rd_ok ? {esid_q[rd_idx[NW-1:0]], 27'b0} : 64'b0;
  assign rd_vsid_word = rd_ok ? vsid_q[rd_idx[NW-1:0]] : 64'b0;

  assign unused_bits = ^{lk_ea[11:0], inv_ea[27:0], wr_esid_word[26:12]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
      lk_valid  <= 1'b0;
      lk_hit    <= 1'b0;
      lk_vsid   <= '0;
      lk_flags  <= '0;
      lk_vpn    <= '0;
      for (int i = 0; i < NENT; i++) begin
        esid_q[i] <= '0;
        vsid_q[i] <= '0;
      end
    end else begin
      lk_valid <= lk_req;
      if (lk_req) begin
        lk_hit <= lk_any;
        if (lk_any) begin
          lk_vsid  <= lk_w[63:12];
          lk_flags <= {lk_w[62], lk_w[8], lk_w[11], lk_w[10], lk_w[9], lk_w[7]};
          lk_vpn   <= lk_w[62] ? ({lk_w[63:12], 28'b0} | {52'b0, lk_ea[39:12]})
                               : ({12'b0, lk_w[63:12], 16'b0} | {64'b0, lk_ea[27:12]});
        end else begin
          lk_vsid  <= '0;
          lk_flags <= '0;
          lk_vpn   <= '0;
        end
      end
      if (inv_all) ent_valid[NENT-1:1] <= '0;
      if (inv_en && inv_any) ent_valid[inv_sel] <= 1'b0;
      if (wr_en && wr_ok) begin
        esid_q[wr_idx[NW-1:0]]    <= wr_esid_word[63:27];
        vsid_q[wr_idx[NW-1:0]]    <= wr_vsid_word;
        ent_valid[wr_idx[NW-1:0]] <= wr_esid_word[27];
      end
    end
  end
endmodule

// File: rtl/slb_array_chk.sv
module slb_array_chk #(
  parameter int NENT = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [63:0]     wr_vsid_word,
  input logic [63:0]     wr_esid_word,
  input logic [11:0]     rd_idx,
  input logic [63:0]     rd_vsid_word,
  input logic            lk_req,
  input logic            lk_valid,
  input logic            lk_hit,
  input logic [51:0]     lk_vsid,
  input logic [5:0]      lk_flags,
  input logic [79:0]     lk_vpn,
  input logic            inv_en,
  input logic            inv_all,
  input logic [NENT-1:0] ent_valid
);
  localparam logic [11:0] NENT12 = 12'(NENT);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_LK_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_valid); // R5
  AST_LK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !lk_valid); // R5
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_hit) |-> (lk_vsid == '0 && lk_flags == '0 && lk_vpn == '0)); // R5
  AST_INV_ALL_SPARES0: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && !wr_en) |=> (ent_valid[NENT-1:1] == '0)); // R8
  AST_OOR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_esid_word[11:0] >= NENT12 && !inv_en && !inv_all) |=> $stable(ent_valid)); // R2
  AST_RDBACK_VSID: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(wr_en) && ($past(wr_esid_word[11:0]) < NENT12) &&
     rd_idx == $past(wr_esid_word[11:0])) |-> (rd_vsid_word == $past(wr_vsid_word))); // R9
endmodule

bind slb_array slb_array_chk #(.NENT(NENT)) i_slb_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_vsid_word(wr_vsid_word),
  .wr_esid_word(wr_esid_word), .rd_idx(rd_idx), .rd_vsid_word(rd_vsid_word),
  .lk_req(lk_req), .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_vsid(lk_vsid),
  .lk_flags(lk_flags), .lk_vpn(lk_vpn), .inv_en(inv_en), .inv_all(inv_all),
  .ent_valid(ent_valid)
);

// File: tb/test_slb_array.sv
`timescale 1ns/1ps
module test_slb_array;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [63:0] wr_vsid_word = '0, wr_esid_word = '0;
  logic [11:0] rd_idx = '0;
  logic [63:0] rd_esid_word, rd_vsid_word;
  logic lk_req = 1'b0;
  logic [63:0] lk_ea = '0;
  logic lk_valid, lk_hit;
  logic [51:0] lk_vsid;
  logic [5:0] lk_flags;
  logic [79:0] lk_vpn;
  logic inv_en = 1'b0;
  logic [63:0] inv_ea = '0;
  logic inv_all = 1'b0;

  always #10 clk = ~clk;

  slb_array i_slb_array (.*);

  typedef struct {
    logic        hit;
    logic [51:0] vsid;
    logic [5:0]  flags;
    logic [79:0] vpn;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0;
  bit done = 0;

  logic [63:0] m_e [64];
  logic [63:0] m_v [64];
  logic        m_val [64];

  function automatic exp_t model_lookup(logic [63:0] ea, string tag);
    exp_t r;
    r.hit = 0; r.vsid = '0; r.flags = '0; r.vpn = '0; r.tag = tag;
    for (int i = 0; i < 64; i++) begin
      logic m;
      m = m_v[i][62] ? ((m_e[i] >> 40) == (ea >> 40)) : ((m_e[i] >> 28) == (ea >> 28));
      if (m_val[i] && m && !r.hit) begin
        r.hit = 1;
        r.vsid = m_v[i][63:12];
        r.flags = {m_v[i][62], m_v[i][8], m_v[i][11], m_v[i][10], m_v[i][9], m_v[i][7]};
        if (m_v[i][62]) r.vpn = (80'(r.vsid) << 28) | 80'((ea >> 12) & 64'hFFFFFFF);
        else            r.vpn = (80'(r.vsid) << 16) | 80'((ea >> 12) & 64'hFFFF);
      end
    end
    return r;
  endfunction

  task automatic model_write(logic [63:0] v, logic [63:0] e);
    int idx = int'(e[11:0]);
    if (idx < 64) begin
      m_e[idx] = e & 64'hFFFF_FFFF_F800_0000;
      m_v[idx] = v;
      m_val[idx] = e[27];
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
    wr_en = 0; lk_req = 0; inv_en = 0; inv_all = 0;
  endtask

  task automatic do_write(logic [63:0] v, logic [63:0] e);
    step();
    wr_en = 1; wr_vsid_word = v; wr_esid_word = e;
    model_write(v, e);
  endtask

  task automatic do_lookup(logic [63:0] ea, string tag);
    step();
    lk_req = 1; lk_ea = ea;
    sb.push_back(model_lookup(ea, tag));
  endtask

  task automatic do_write_lookup(logic [63:0] v, logic [63:0] e, logic [63:0] ea, string tag);
    step();
    lk_req = 1; lk_ea = ea;
    sb.push_back(model_lookup(ea, tag));
    wr_en = 1; wr_vsid_word = v; wr_esid_word = e;
    model_write(v, e);
  endtask

  task automatic do_inv(logic [63:0] ea);
    exp_t r;
    step();
    inv_en = 1; inv_ea = ea;
    r = model_lookup(ea, "");
    for (int i = 0; i < 64; i++) begin
      logic m;
      m = m_v[i][62] ? ((m_e[i] >> 40) == (ea >> 40)) : ((m_e[i] >> 28) == (ea >> 28));
      if (r.hit && m_val[i] && m) begin
        m_val[i] = 0;
        r.hit = 0;
      end
    end
  endtask

  task automatic do_inv_all();
    step();
    inv_all = 1;
    for (int i = 1; i < 64; i++) m_val[i] = 0;
  endtask

  task automatic check_rd(logic [11:0] idx, string tag);
    logic [63:0] ee, ev;
    step();
    rd_idx = idx;
    ee = (idx < 64) ? m_e[idx] : 64'b0;
    ev = (idx < 64) ? m_v[idx] : 64'b0;
    #1;
    checks++;
    if (rd_esid_word !== ee || rd_vsid_word !== ev) begin
      errors++;
      $display("FAIL %s: readback idx %0d actual %h/%h expected %h/%h",
               tag, idx, rd_esid_word, rd_vsid_word, ee, ev);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && lk_valid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R5: strobe without request actual lk_valid=1 expected 0");
      end else begin
        exp_t x;
        x = sb.pop_front();
        if (lk_hit !== x.hit || lk_vsid !== x.vsid || lk_flags !== x.flags || lk_vpn !== x.vpn) begin
          errors++;
          $display("FAIL %s: actual hit=%b vsid=%h flags=%b vpn=%h expected hit=%b vsid=%h flags=%b vpn=%h",
                   x.tag, lk_hit, lk_vsid, lk_flags, lk_vpn, x.hit, x.vsid, x.flags, x.vpn);
        end
      end
    end
  end

  localparam logic [63:0] V27 = 64'h1 << 27;
  localparam logic [63:0] EA_A = (64'h1_2345_6789 << 28) | 64'h5A5_B123;
  localparam logic [63:0] E_A  = (64'h1_2345_6789 << 28) | V27 | (64'h7FFF << 12) | 64'd3;
  localparam logic [63:0] V_A  = (64'hABCDE << 12) | (64'h1 << 11) | (64'h1 << 9);
  localparam logic [63:0] E_B  = (64'hC0FFEE << 40) | (64'h777 << 28) | V27 | 64'd5;
  localparam logic [63:0] V_B  = (64'h1 << 62) | (64'h1234 << 12) | (64'h1 << 10) | (64'h1 << 8) | (64'h1 << 7);
  localparam logic [63:0] EA_B = (64'hC0FFEE << 40) | 64'h12_3456_7ABC;
  localparam logic [63:0] EA_P = (64'hAB1 << 28) | 64'h123_4000;

  initial begin
    for (int i = 0; i < 64; i++) begin m_e[i] = '0; m_v[i] = '0; m_val[i] = 0; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1;
    checks++;
    if (lk_valid !== 1'b0) begin errors++; $display("FAIL R11: lk_valid actual %b expected 0", lk_valid); end
    check_rd(12'd0, "R11");
    check_rd(12'd63, "R11");
    do_lookup(EA_A, "R11 empty array miss");

    do_write(V_A, E_A);
    do_lookup(EA_A, "R1 R3 R6 256MB hit");
    do_lookup(EA_A ^ (64'h1 << 28), "R3 256MB bit 28 differs miss");
    check_rd(12'd3, "R9 masked esid word");

    do_write(V_B, E_B);
    do_lookup(EA_B, "R3 R6 1TB hit ignoring bits 39:28");
    do_lookup(EA_B ^ (64'h1 << 40), "R3 1TB bit 40 differs miss");
    check_rd(12'd5, "R9 full vsid word");

    do_write(64'd9 << 12, (64'hAB1 << 28) | V27 | 64'd9);
    do_write(64'd2 << 12, (64'hAB1 << 28) | V27 | 64'd2);
    do_lookup(EA_P, "R4 lowest index wins");
    do_inv(EA_P);
    do_lookup(EA_P, "R7 next match after invalidate");
    do_inv(EA_P);
    do_lookup(EA_P, "R7 both removed miss");
    do_inv(64'hFFFF_0000_0000_0000);
    do_lookup(EA_A, "R7 miss invalidate leaves 256MB entry");
    do_lookup(EA_B, "R7 miss invalidate leaves 1TB entry");

    do_write(64'd11 << 12, (64'h5 << 28) | 64'd11);
    do_lookup(64'h5 << 28, "R1 entry written invalid misses");

    do_write(64'd36 << 12, (64'h777 << 28) | V27 | 64'd100);
    do_lookup(64'h777 << 28, "R2 out of range write ignored");
    check_rd(12'd36, "R2 no alias to slot 36");
    check_rd(12'd100, "R9 out of range read 0");

    do_write_lookup(64'd20 << 12, (64'hDEAD << 28) | V27 | 64'd20, 64'hDEAD << 28, "R10 same cycle sees old contents");
    do_lookup(64'hDEAD << 28, "R10 write visible next");

    do_write(64'd77 << 12, (64'h42 << 28) | V27 | 64'd0);
    do_inv_all();
    do_lookup(64'h42 << 28, "R8 slot 0 survives");
    do_lookup(EA_A, "R8 slot 3 cleared");
    do_lookup(EA_B, "R8 slot 5 cleared");
    do_lookup(64'hDEAD << 28, "R8 slot 20 cleared");

    step();
    repeat (4) @(posedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R5: missing results actual %0d pending expected 0", sb.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule